// File: doc/BRIEF.md
# Presettable Cascadable Decade Counter

This block is one decimal digit of a synchronous counter. It holds a four-bit value that steps through 0 to 9 and back to 0. It takes a parallel preset, an active-low clear and two count enables. A terminal-count carry lets the digits be chained into a multi-digit counter that runs off a single shared clock. In that chain, the carry of each digit feeds both enables of the digit above it.

The clear has top priority, the preset comes second and counting comes last. An elaboration-time parameter sets whether the clear waits for the clock edge or forces zero at once. The default is to wait for the edge. Of the two enables, only `enableT` also gates the carry output. This lets a higher digit be stalled without breaking the carry chain below it.

Top module: `decade_stage`

## Requirements
- R1: With `ASYNC_CLEAR`=0 (the default), `clearN` low zeroes `count` at the next rising clock edge and not before. It does so whatever `loadN`, `preset` and the enables are.
- R2: With `ASYNC_CLEAR`=1, `clearN` low zeroes `count` at once, with no clock edge, and `count` stays zero while `clearN` is low.
- R3: With `clearN` high and `loadN` low, a rising edge copies `preset` into `count` whatever the enable levels are.
- R4: With `clearN` and `loadN` high and both `enableP` and `enableT` high, a rising edge adds one to `count`. `count` is a plain binary value with bit 0 as the least significant bit.
- R5: With `clearN` and `loadN` high and either enable low, `count` keeps its value across a rising edge.
- R6: A counting edge taken at `count`=9 (4'b1001) gives `count`=0.
- R7: `carryOut` is high exactly when `enableT` is high and `count`=9. It follows `enableT` without a clock edge and does not depend on `enableP`.
- R8: Counting from a preset value of 10 to 15 advances one step per edge, and 15 wraps to 0. `carryOut` stays low at every value from 10 to 15.
- R9: Two stages on one clock, with the low stage's `carryOut` driving both enables of the high stage, count from 00 to 99 and wrap to 00. The high stage's `carryOut` is high at 99 while counting is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clearN | input | 1 | Active-low clear, highest priority |
| loadN | input | 1 | Active-low parallel preset strobe |
| preset | input | 4 | Value loaded when `loadN` is low |
| enableP | input | 1 | Count enable that does not gate the carry |
| enableT | input | 1 | Count enable that also gates the carry |
| count | output | 4 | Current digit value |
| carryOut | output | 1 | Terminal-count carry |

## Verification
Clear, preset and counting can all be requested on the same edge. The bench drives `clearN` and `loadN` low together while both enables are high, and it expects zero rather than the preset value. It also drives `loadN` low with the enables high and expects the preset value rather than an increment. A second overlap comes at the terminal count: the carry and the wrap to zero must appear together in the cascade. The high digit must step on exactly the edge where the low digit goes from 9 to 0, and the bench checks this against a decimal model on every cycle through a full pass of 100 values.

// File: rtl/decade_pkg.sv
package decade_pkg;
  // Strobes from the control decoder to the datapath; at most one is set.
  typedef struct packed {
    logic clr;   // clear request (sync mode) or live clear level (async mode)
    logic ld;    // take the preset value
    logic inc;   // advance by one
  } ctrl_strobe_t;
endpackage

// File: rtl/decade_ctrl.sv
module decade_ctrl
  import decade_pkg::*;
(
  input  logic         clearN,
  input  logic         loadN,
  input  logic         enableP,
  input  logic         enableT,
  output ctrl_strobe_t strobes
);
  // Fixed priority: clear over preset over count.
  always_comb begin
    strobes     = '0;
    strobes.clr = !clearN;
    if (clearN) begin
      if (!loadN)                   strobes.ld  = 1'b1;
      else if (enableP && enableT)  strobes.inc = 1'b1;
    end
  end
endmodule

// File: rtl/decade_dp.sv
module decade_dp
  import decade_pkg::*;
#(
  parameter int  DIGIT_W     = 4,
  parameter int  TERMINAL    = 9,
  parameter bit  ASYNC_CLEAR = 1'b0
) (
  input  logic               clk,
  input  ctrl_strobe_t       strobes,
  input  logic [DIGIT_W-1:0] preset,
  input  logic               enableT,
  output logic [DIGIT_W-1:0] count,
  output logic               carryOut
);
  localparam logic [DIGIT_W-1:0] TermVal = DIGIT_W'(TERMINAL);

  logic [DIGIT_W-1:0] countQ;
  logic [DIGIT_W-1:0] nextCount;
  logic               atTerm;
  logic               clrNow;

  assign clrNow = strobes.clr;
  assign atTerm = (countQ == TermVal);

  always_comb begin
    if (clrNow)           nextCount = '0;
    else if (strobes.ld)  nextCount = preset;
    else if (strobes.inc) nextCount = atTerm ? '0 : countQ + 1'b1;
    else                  nextCount = countQ;
  end

  generate
    if (ASYNC_CLEAR) begin : g_async_clr
      always_ff @(posedge clk or posedge clrNow) begin
        if (clrNow) countQ <= '0;
        else        countQ <= nextCount;
      end
    end else begin : g_sync_clr
      always_ff @(posedge clk) begin
        countQ <= nextCount;
      end
    end
  endgenerate

  assign count    = countQ;
  assign carryOut = enableT && atTerm;

  p_load_r3: assert property (@(posedge clk) disable iff (clrNow)
    strobes.ld |=> (count == $past(preset)));

  p_step_r4: assert property (@(posedge clk) disable iff (clrNow)
    (strobes.inc && count < TermVal) |=> (count == $past(count) + 1'b1));

  p_hold_r5: assert property (@(posedge clk) disable iff (clrNow)
    (!strobes.ld && !strobes.inc) |=> $stable(count));

  p_wrap_r6: assert property (@(posedge clk) disable iff (clrNow)
    (strobes.inc && count == TermVal) |=> (count == '0));
endmodule

// File: rtl/decade_stage.sv
module decade_stage
  import decade_pkg::*;
#(
  parameter int DIGIT_W     = 4,
  parameter int TERMINAL    = 9,
  parameter bit ASYNC_CLEAR = 1'b0
) (
  input  logic               clk,
  input  logic               clearN,
  input  logic               loadN,
  input  logic [DIGIT_W-1:0] preset,
  input  logic               enableP,
  input  logic               enableT,
  output logic [DIGIT_W-1:0] count,
  output logic               carryOut
);
  ctrl_strobe_t strobes;

  decade_ctrl u_ctrl (
    .clearN  (clearN),
    .loadN   (loadN),
    .enableP (enableP),
    .enableT (enableT),
    .strobes (strobes)
  );

  decade_dp #(
    .DIGIT_W     (DIGIT_W),
    .TERMINAL    (TERMINAL),
    .ASYNC_CLEAR (ASYNC_CLEAR)
  ) u_dp (
    .clk      (clk),
    .strobes  (strobes),
    .preset   (preset),
    .enableT  (enableT),
    .count    (count),
    .carryOut (carryOut)
  );

  p_carry_gate_r7: assert property (@(posedge clk) disable iff (!clearN)
    carryOut |-> (enableT && count == DIGIT_W'(TERMINAL)));
endmodule

// File: tb/sim_decade_stage.sv
module sim_decade_stage;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // sync-clear stage under test
  logic       clearN = 1'b0, loadN = 1'b1, enableP = 1'b0, enableT = 1'b0;
  logic [3:0] preset = '0;
  logic [3:0] count;
  logic       carryOut;

  // async-clear stage
  logic       aClearN = 1'b0, aLoadN = 1'b1, aEn = 1'b0;
  logic [3:0] aPreset = '0;
  logic [3:0] aCount;
  logic       aCarry;

  // two-digit cascade
  logic       cClearN = 1'b0, cEn = 1'b0;
  logic [3:0] loCount, hiCount;
  logic       loCarry, hiCarry;

  decade_stage u0 (
    .clk(clk), .clearN(clearN), .loadN(loadN), .preset(preset),
    .enableP(enableP), .enableT(enableT), .count(count), .carryOut(carryOut));

  decade_stage #(.ASYNC_CLEAR(1'b1)) uAsync (
    .clk(clk), .clearN(aClearN), .loadN(aLoadN), .preset(aPreset),
    .enableP(aEn), .enableT(aEn), .count(aCount), .carryOut(aCarry));

  decade_stage uLo (
    .clk(clk), .clearN(cClearN), .loadN(1'b1), .preset(4'd0),
    .enableP(cEn), .enableT(cEn), .count(loCount), .carryOut(loCarry));

  decade_stage uHi (
    .clk(clk), .clearN(cClearN), .loadN(1'b1), .preset(4'd0),
    .enableP(loCarry), .enableT(loCarry), .count(hiCount), .carryOut(hiCarry));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance one edge, then settle a quarter period past it
  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic t_reset();
    clearN = 1'b0; loadN = 1'b0; preset = 4'd8; enableP = 1'b1; enableT = 1'b1;
    step();
    chk("R1 reset count", count, 0);
    chk("R1 reset carry", carryOut, 0);
  endtask

  task automatic t_load();
    clearN = 1'b1; loadN = 1'b0; preset = 4'd7; enableP = 1'b0; enableT = 1'b0;
    step();
    chk("R3 load enables low", count, 7);
    preset = 4'd3; enableP = 1'b1; enableT = 1'b1;
    step();
    chk("R3 load beats count", count, 3);
  endtask

  task automatic t_count_wrap();
    loadN = 1'b1; enableP = 1'b1; enableT = 1'b1;
    for (int v = 4; v <= 9; v++) begin
      step();
      chk("R4 increment", count, v);
      chk("R7 carry while counting", carryOut, (v == 9) ? 1 : 0);
    end
    step();
    chk("R6 wrap 9 to 0", count, 0);
    chk("R7 carry after wrap", carryOut, 0);
  endtask

  task automatic t_hold_carry();
    loadN = 1'b0; preset = 4'd9; step();
    loadN = 1'b1; enableP = 1'b0; enableT = 1'b1;
    #1 chk("R7 carry ignores enableP", carryOut, 1);
    step();
    chk("R5 hold enableP low", count, 9);
    enableT = 1'b0;
    #1 chk("R7 carry follows enableT", carryOut, 0);
    enableP = 1'b1;
    step();
    chk("R5 hold enableT low", count, 9);
    enableT = 1'b1;
    #1 chk("R7 carry returns", carryOut, 1);
  endtask

  task automatic t_clear_priority();
    loadN = 1'b0; preset = 4'd5; step();
    loadN = 1'b0; preset = 4'd8; clearN = 1'b0; enableP = 1'b1; enableT = 1'b1;
    #1 chk("R1 sync clear waits for edge", count, 5);
    step();
    chk("R1 clear beats load", count, 0);
    clearN = 1'b1; loadN = 1'b1;
  endtask

  task automatic t_out_of_range();
    loadN = 1'b0; preset = 4'd10; enableP = 1'b1; enableT = 1'b1; step();
    chk("R8 preset 10", count, 10);
    loadN = 1'b1;
    chk("R8 no carry at 10", carryOut, 0);
    for (int v = 11; v <= 16; v++) begin
      step();
      chk("R8 advance", count, v % 16);
      chk("R8 carry low", carryOut, 0);
    end
  endtask

  task automatic t_async();
    aClearN = 1'b1; aLoadN = 1'b0; aPreset = 4'd6; step();
    chk("R2 async preload", aCount, 6);
    aLoadN = 1'b1;
    aClearN = 1'b0;
    #1 chk("R2 immediate clear", aCount, 0);
    aEn = 1'b1;
    step();
    chk("R2 held at zero", aCount, 0);
    aClearN = 1'b1;
    step();
    chk("R2 counts after release", aCount, 1);
  endtask

  task automatic t_cascade();
    int expVal;
    cClearN = 1'b0; step();
    cClearN = 1'b1; cEn = 1'b1;
    chk("R9 cascade cleared", hiCount * 10 + loCount, 0);
    for (int n = 1; n <= 100; n++) begin
      step();
      expVal = n % 100;
      chk("R9 cascade value", hiCount * 10 + loCount, expVal);
      chk("R9 high carry", hiCarry, (expVal == 99) ? 1 : 0);
    end
    cEn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load();
    t_count_wrap();
    t_hold_carry();
    t_clear_priority();
    t_out_of_range();
    t_async();
    t_cascade();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule